// File: doc/BRIEF.md
# Interrupt source routing matrix

This block steers a large set of peripheral interrupt request lines onto the numbered entry inputs of an interrupt controller. Every source owns one word-wide map register. The register holds a 6-bit destination entry index, and the source's request appears on the controller input with that number. Several sources may name the same destination, and their requests are then combined by a logical OR. Writing zero to a map register detaches its source from every destination.

The value placed in a map register is the controller's own entry index, not a CPU line number. External CPU lines 1..31 therefore appear as entries 17..47, because the lines start at an entry offset of 16. Software programs the registers through a simple byte-addressed register port with one word per source. The routing path from request inputs to destination outputs has no register in it, so a request reaches its destination in the same cycle. Only the map values are clocked.

Top module: `irq_route_matrix`

## Requirements
- R1: After reset every map register reads 0 and every destination output is low, whatever the source inputs are.
- R2: A write with `reg_we` high to byte address 4*s, with s below NUM_SRC, stores `reg_wdata[5:0]` into the map register of source s at the next rising clock edge. Data bits 31..6 are ignored.
- R3: `reg_rdata` presents the map register selected by `reg_addr[ADDR_W-1:2]` combinationally, zero-extended to 32 bits. Address bits 1..0 do not select anything. For example, source 92 is at byte 0x170 and source 53 is at byte 0xD4.
- R4: Destination output k, for k in 1..63, is high exactly when at least one source whose map register equals k has its request input high.
- R5: A source whose map register holds 0 drives no destination. Destination output 0 is never driven high.
- R6: Sources that share one destination are ORed onto it. A single source drives only the one destination it names and no other output.
- R7: An access to a word index at or beyond NUM_SRC reads as 0, and a write there changes no map register.
- R8: A change on a source input reaches the destination outputs without a clock edge. A new map value takes effect from the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Write strobe for the map register port |
| reg_addr | input | ADDR_W (12) | Byte address; bits ADDR_W-1..2 select the source word |
| reg_wdata | input | 32 | Write data; only bits 5..0 are kept |
| reg_rdata | output | 32 | Read data of the selected word, zero-extended |
| src_irq | input | NUM_SRC (96) | Peripheral interrupt request lines |
| dst_irq | output | 64 | Controller entry inputs, index = destination entry number |

## Verification
Two cases are hard to reach from the ports. The first is several sources merging onto one destination while other sources point elsewhere. The second is a map value of zero hiding behind a source that is asserting. The stimulus sweeps every source through a distinct arithmetic map value, which includes zero for some sources and repeated destinations for others. It then drives one-hot and mixed request patterns, and the expected output vector is computed from the bench's own copy of the map. Writes to every word beyond the last source are followed by a full read-back of the valid registers, which shows that nothing was disturbed.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int IDX_W   = 6;
  localparam int NUM_DST = 1 << IDX_W;
  localparam int DATA_W  = 32;
  typedef logic [IDX_W-1:0] map_idx_t;
endpackage

// File: rtl/irqm_rst_sync.sv
module irqm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/irqm_map_regs.sv
module irqm_map_regs
  import irqm_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int ADDR_W  = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_SRC-1:0][IDX_W-1:0]   map_o
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]              word_idx;
  logic                           in_range;
  logic [NUM_SRC-1:0]             wr_hit;
  logic [NUM_SRC-1:0][IDX_W-1:0]  map_q;
  logic [NUM_SRC-1:0][IDX_W-1:0]  map_d;
  map_idx_t                       rd_val;

  assign word_idx = addr[ADDR_W-1:2];

  always_comb begin
    wr_hit   = '0;
    in_range = 1'b0;
    rd_val   = '0;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (word_idx == WIDX_W'(s)) begin
        in_range  = 1'b1;
        rd_val    = map_q[s];
        wr_hit[s] = we;
      end
    end
  end

  always_comb begin
    map_d = map_q;
    for (int s = 0; s < NUM_SRC; s++) begin
      if (wr_hit[s]) map_d[s] = wdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     map_q <= '0;
    else if (we)    map_q <= map_d;
  end

  assign rdata = {{(DATA_W-IDX_W){1'b0}}, rd_val};
  assign map_o = map_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_wr_chk
    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && word_idx == WIDX_W'(s)) |=> map_q[s] == $past(wdata[IDX_W-1:0]));
  end

  assert_outside_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !in_range) |=> $stable(map_q));

  assert_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(we && in_range) && $stable(addr)) |->
      rdata == {{(DATA_W-IDX_W){1'b0}}, $past(wdata[IDX_W-1:0])});
endmodule

// File: rtl/irqm_or_fabric.sv
module irqm_or_fabric
  import irqm_pkg::*;
#(
  parameter int NUM_SRC = 96
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_SRC-1:0]             src,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]  map,
  output logic [NUM_DST-1:0]             dst
);
  logic [NUM_SRC-1:0][NUM_DST-1:0] hot;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_dec
    always_comb begin
      hot[s] = '0;
      if (src[s]) hot[s] = NUM_DST'(1) << map[s];
    end
  end

  always_comb begin
    dst = '0;
    for (int k = 1; k < NUM_DST; k++) begin
      for (int s = 0; s < NUM_SRC; s++) dst[k] = dst[k] | hot[s][k];
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_route_chk
    assert_source_reaches_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src[s] && map[s] != '0) |-> dst[map[s]]);
  end

  assert_quiet_sources_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (dst == '0));
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irqm_pkg::*;
#(
  parameter int NUM_SRC = 96,
  parameter int ADDR_W  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NUM_SRC-1:0]  src_irq,
  output logic [NUM_DST-1:0]  dst_irq
);
  logic                           rst_sync_n;
  logic [NUM_SRC-1:0][IDX_W-1:0]  map;

  irqm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irqm_map_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .map_o (map)
  );

  irqm_or_fabric #(.NUM_SRC(NUM_SRC)) u_fabric (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .src   (src_irq),
    .map   (map),
    .dst   (dst_irq)
  );
endmodule

// File: tb/irq_route_matrix_tb.sv
module irq_route_matrix_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 96;
  localparam int AW = 12;
  localparam int NWORDS = 1 << (AW - 2);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_we = 1'b0;
  logic [AW-1:0]   reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NSRC-1:0] src_irq = '0;
  logic [63:0]     dst_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] exp_map [NSRC];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_matrix #(.NUM_SRC(NSRC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_irq(src_irq), .dst_irq(dst_irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int word, input logic [31:0] data);
    @(negedge clk);
    reg_addr  = AW'(word * 4);
    reg_wdata = data;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int word, input logic [31:0] exp);
    reg_addr = AW'(word * 4);
    #1;
    check(req, 64'(reg_rdata), 64'(exp));
  endtask

  function automatic logic [63:0] model(input logic [NSRC-1:0] s);
    logic [63:0] r = '0;
    for (int i = 0; i < NSRC; i++)
      if (s[i] && exp_map[i] != 6'd0) r[exp_map[i]] = 1'b1;
    return r;
  endfunction

  task automatic drv_chk(input string req, input logic [NSRC-1:0] s);
    src_irq = s;
    #1;
    check(req, dst_irq, model(s));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NSRC; i++) exp_map[i] = 6'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state of registers and outputs
    for (int i = 0; i < NSRC; i++) rd_chk("R1 reset map", i, 32'd0);
    src_irq = '1; #1;
    check("R1 reset outputs", dst_irq, 64'd0);
    src_irq = '0;

    // R2/R3: write every source with garbage in the upper bits
    for (int i = 0; i < NSRC; i++) begin
      exp_map[i] = 6'((i * 37 + 11) % 64);
      wr(i, {~26'(i), exp_map[i]});
    end
    for (int i = 0; i < NSRC; i++) rd_chk("R2 R3 readback", i, {26'd0, exp_map[i]});
    reg_addr = AW'(12'h170); #1;
    check("R3 source 92 offset", 64'(reg_rdata), 64'(exp_map[92]));
    reg_addr = AW'(12'hD6); #1;
    check("R3 source 53 offset low bits ignored", 64'(reg_rdata), 64'(exp_map[53]));

    // R4/R5/R6: one-hot sweep
    for (int i = 0; i < NSRC; i++) drv_chk("R4 R5 R6 one-hot", NSRC'(1) << i);
    drv_chk("R4 all sources", '1);
    drv_chk("R4 even sources", {(NSRC/2){2'b01}});
    drv_chk("R4 odd sources", {(NSRC/2){2'b10}});
    drv_chk("R4 none", '0);

    // R6: merge several sources onto destination 20 (entry for CPU line 4)
    for (int i = 0; i < 8; i++) begin exp_map[i] = 6'd20; wr(i, 32'd20); end
    for (int i = 0; i < 8; i++) drv_chk("R6 merged one", NSRC'(1) << i);
    drv_chk("R6 merged all", NSRC'(8'hFF));
    src_irq = NSRC'(8'h24); #1;
    check("R6 merged single dest", dst_irq, 64'd1 << 20);

    // R5: unmap a source while it asserts
    src_irq = NSRC'(1) << 40;
    exp_map[40] = 6'd0;
    wr(40, 32'hFFFF_FFC0);
    #1;
    check("R5 unmapped source", dst_irq, 64'd0);
    rd_chk("R5 unmapped readback", 40, 32'd0);

    // R8: new map takes effect at the storing edge; source change needs no clock
    @(negedge clk);
    reg_addr = AW'(40 * 4); reg_wdata = 32'd47; reg_we = 1'b1;
    #1;
    check("R8 before edge", dst_irq, 64'd0);
    @(posedge clk); #1;
    check("R8 after edge", dst_irq, 64'd1 << 47);
    exp_map[40] = 6'd47;
    @(negedge clk); reg_we = 1'b0;
    #(CLK_PERIOD/4);
    src_irq = '0; #1;
    check("R8 source drop mid-cycle", dst_irq, 64'd0);
    src_irq = NSRC'(1) << 40; #1;
    check("R8 source rise mid-cycle", dst_irq, 64'd1 << 47);
    src_irq = '0;

    // R7: words beyond the last source
    for (int w = NSRC; w < NWORDS; w++) begin
      wr(w, 32'h0000_002A);
      rd_chk("R7 outside reads zero", w, 32'd0);
    end
    for (int i = 0; i < NSRC; i++) rd_chk("R7 valid maps unchanged", i, {26'd0, exp_map[i]});
    drv_chk("R7 routing unchanged", '1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule